// File: doc/BRIEF.md
# Drive security lock controller

This block keeps the device-side security state of a storage drive. It stores a user password and a master password, each 16 words wide. It tracks four conditions: security enabled, security level, locked and frozen. A command decoder upstream hands it one security command per cycle, as a command byte with a control word and a password payload. One cycle later the block answers with accept or abort.

While the drive is locked, media reads and writes are refused. A successful erase-unit command raises a one-cycle erase request, which a media engine elsewhere acts on.

The `pwr_cycle` input stands for a power-off/on or a hard reset of the drive. The stored passwords survive it, so a drive with a user password set comes back locked. `rst_n` is the factory clear: both passwords return to their initial values and security is disabled.

Top module: `dsk_lock_ctrl`

## Requirements
- R1: Every cycle with `cmd_valid` high and `pwr_cycle` low is answered in the next cycle by `rsp_valid` high for exactly one cycle, with `rsp_abort` high for abort and low for accept. Command codes outside F1h..F6h are accepted and leave the security state unchanged.
- R2: Set password (F1h) is handled as follows.
  - With control bit 0 = 0 it stores the user password, sets `sec_enabled`, and takes the level from control bit 8 (0 = high, 1 = maximum), shown on `sec_level_max`.
  - With control bit 0 = 1 it stores only the master password.
  - It is aborted while locked.
- R3: Unlock (F2h) works as follows.
  - Control bit 0 picks the user (0) or master (1) password for comparison against the payload.
  - A match clears `sec_locked` and is accepted.
  - A mismatch is aborted and the drive stays locked.
  - With security disabled, unlock is accepted.
- R4: At maximum level, a master-password unlock or disable is aborted even when the password matches, and erase unit is accepted only with the master password.
- R5: While frozen, commands F1h, F2h, F3h, F4h and F6h are aborted and change no state. Freeze lock (F5h) is always accepted, and the drive stays frozen.
- R6: `sec_frozen`, once set, is cleared only by `pwr_cycle` or `rst_n`.
- R7: Disable password (F6h) with a matching password clears the user password, `sec_enabled` and `sec_locked`, and keeps the master password. A mismatch, or security already disabled, is aborted.
- R8: Erase unit (F4h) is accepted only in the cycle after an accepted erase prepare (F3h) and with a matching password. It then pulses `erase_req` for one cycle (the same cycle as `rsp_valid`), disables security and clears the lock.
- R9: Any command other than F4h following erase prepare cancels the preparation, so a later F4h is aborted with no `erase_req`. An F4h itself consumes the preparation, whether it is accepted or aborted.
- R10: `pwr_cycle` sets `sec_locked` to `sec_enabled`, clears frozen and the erase preparation, and takes precedence over a command in the same cycle. Such a command gets no response.
- R11: `media_grant` equals `media_req` while unlocked and is low while locked.
- R12: After `rst_n`, the flags `sec_enabled`, `sec_locked`, `sec_frozen` and `sec_level_max` are low, as are `rsp_valid` and `erase_req`. The master password holds the parameter `MASTER_INIT` (default all zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low factory clear |
| pwr_cycle | input | 1 | One-cycle power cycle / hard reset event |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 8 | Command byte |
| ctrl_word | input | 16 | Control word; bit 0 = password select, bit 8 = level |
| pw_data | input | 256 | Password payload, 16 words of 16 bits |
| rsp_valid | output | 1 | Response strobe, one cycle after the command |
| rsp_abort | output | 1 | 1 = aborted, 0 = accepted |
| erase_req | output | 1 | One-cycle media erase request |
| media_req | input | 1 | Media access requested |
| media_grant | output | 1 | Media access allowed |
| sec_enabled | output | 1 | User password set |
| sec_locked | output | 1 | Drive locked |
| sec_frozen | output | 1 | Lock-changing commands refused |
| sec_level_max | output | 1 | Maximum security level |

## Verification
A wrong lock flag shows at `media_grant` in the same cycle as a media request. It also shows at `rsp_abort` on the next unlock, one cycle after that command. A lost frozen flag or a stale erase preparation appears as an accept where an abort is due, in the response cycle of the very next lock-changing command. A password stored to the wrong slot stays invisible until a later unlock or disable compares against it. For that reason the scenarios re-lock through `pwr_cycle` and retry with each password.

// File: rtl/dsk_lock_pkg.sv
// Shared constants for the drive security lock controller.
// Assumes the command byte is already decoded to the security codes below.
package dsk_lock_pkg;
    localparam logic [7:0] CMD_SET_PW   = 8'hF1;
    localparam logic [7:0] CMD_UNLOCK   = 8'hF2;
    localparam logic [7:0] CMD_ERASE_PR = 8'hF3;
    localparam logic [7:0] CMD_ERASE_UN = 8'hF4;
    localparam logic [7:0] CMD_FREEZE   = 8'hF5;
    localparam logic [7:0] CMD_DIS_PW   = 8'hF6;
    localparam int unsigned CTRL_SEL_BIT = 0;
    localparam int unsigned CTRL_LVL_BIT = 8;
endpackage

// File: rtl/dsk_pw_cmp.sv
// Word-wise password equality compare.
// Purely combinational; a and b are WORDS words of WORD_W bits each.
module dsk_pw_cmp #(
    parameter int unsigned WORDS  = 16,
    parameter int unsigned WORD_W = 16,
    localparam int unsigned PW_W  = WORDS * WORD_W
) (
    input  logic [PW_W-1:0] a,
    input  logic [PW_W-1:0] b,
    output logic            eq
);
    logic [WORDS-1:0] word_eq;

    // one equality flag per password word
    for (genvar i = 0; i < WORDS; i++) begin : g_word
        assign word_eq[i] = (a[i*WORD_W +: WORD_W] == b[i*WORD_W +: WORD_W]);
    end

    assign eq = &word_eq;
endmodule

// File: rtl/dsk_pw_bank.sv
// Holds the user and master passwords and compares both against the payload.
// Assumes at most one of the write/clear strobes acts per cycle; clear wins.
module dsk_pw_bank #(
    parameter int unsigned WORDS  = 16,
    parameter int unsigned WORD_W = 16,
    localparam int unsigned PW_W  = WORDS * WORD_W,
    parameter logic [PW_W-1:0] MASTER_INIT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_user,
    input  logic            wr_master,
    input  logic            clr_user,
    input  logic [PW_W-1:0] pw_in,
    output logic            user_eq,
    output logic            master_eq
);
    logic [PW_W-1:0] user_q;
    logic [PW_W-1:0] master_q;

    // password storage update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            user_q   <= '0;
            master_q <= MASTER_INIT;
        end else begin
            if (clr_user)     user_q <= '0;
            else if (wr_user) user_q <= pw_in;
            if (wr_master)    master_q <= pw_in;
        end
    end

    dsk_pw_cmp #(.WORDS(WORDS), .WORD_W(WORD_W)) u_cmp_user (
        .a(user_q), .b(pw_in), .eq(user_eq)
    );
    dsk_pw_cmp #(.WORDS(WORDS), .WORD_W(WORD_W)) u_cmp_master (
        .a(master_q), .b(pw_in), .eq(master_eq)
    );
endmodule

// File: rtl/dsk_lock_fsm.sv
// Security state flags and command decision logic.
// Assumes password match flags are valid combinationally in the command cycle.
module dsk_lock_fsm
    import dsk_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_cycle,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    input  logic       sel_master,
    input  logic       lvl_bit,
    input  logic       user_eq,
    input  logic       master_eq,
    output logic       wr_user,
    output logic       wr_master,
    output logic       clr_user,
    output logic       rsp_valid,
    output logic       rsp_abort,
    output logic       erase_req,
    output logic       enabled,
    output logic       locked,
    output logic       frozen,
    output logic       level_max
);
    logic prepared;
    logic abort_c, unlock_c, erase_c, disable_c, freeze_c;
    logic pw_ok, erase_ok, act;

    assign act = cmd_valid && !pwr_cycle;

    // command decision: abort status and the actions of an accepted command
    always_comb begin
        pw_ok     = sel_master ? (master_eq && !level_max) : user_eq;
        erase_ok  = sel_master ? master_eq : (user_eq && !level_max);
        abort_c   = 1'b0;
        unlock_c  = 1'b0;
        erase_c   = 1'b0;
        disable_c = 1'b0;
        freeze_c  = 1'b0;
        wr_user   = 1'b0;
        wr_master = 1'b0;
        unique case (cmd_code)
            CMD_SET_PW: begin
                abort_c   = frozen || locked;
                wr_user   = act && !abort_c && !sel_master;
                wr_master = act && !abort_c && sel_master;
            end
            CMD_UNLOCK: begin
                abort_c  = frozen || (enabled && !pw_ok);
                unlock_c = !abort_c;
            end
            CMD_ERASE_PR: abort_c = frozen;
            CMD_ERASE_UN: begin
                abort_c = frozen || !prepared || !erase_ok;
                erase_c = !abort_c;
            end
            CMD_FREEZE: freeze_c = 1'b1;
            CMD_DIS_PW: begin
                abort_c   = frozen || !enabled || !pw_ok;
                disable_c = !abort_c;
            end
            default: ;
        endcase
        clr_user = act && (erase_c || disable_c);
    end

    // state flag and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enabled   <= 1'b0;
            locked    <= 1'b0;
            frozen    <= 1'b0;
            level_max <= 1'b0;
            prepared  <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_abort <= 1'b0;
            erase_req <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            erase_req <= 1'b0;
            if (pwr_cycle) begin
                locked   <= enabled;
                frozen   <= 1'b0;
                prepared <= 1'b0;
            end else if (cmd_valid) begin
                rsp_valid <= 1'b1;
                rsp_abort <= abort_c;
                prepared  <= (cmd_code == CMD_ERASE_PR) && !abort_c;
                if (wr_user) begin
                    enabled   <= 1'b1;
                    level_max <= lvl_bit;
                end
                if (unlock_c) locked <= 1'b0;
                if (freeze_c) frozen <= 1'b1;
                if (erase_c || disable_c) begin
                    enabled   <= 1'b0;
                    locked    <= 1'b0;
                    level_max <= 1'b0;
                end
                if (erase_c) erase_req <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dsk_lock_ctrl.sv
// Top of the drive security lock controller: password bank, state machine
// and media gate. Assumes one command per cycle and a one-cycle pwr_cycle.
module dsk_lock_ctrl
    import dsk_lock_pkg::*;
#(
    parameter int unsigned WORDS  = 16,
    parameter int unsigned WORD_W = 16,
    localparam int unsigned PW_W  = WORDS * WORD_W,
    parameter logic [PW_W-1:0] MASTER_INIT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_cycle,
    input  logic            cmd_valid,
    input  logic [7:0]      cmd_code,
    input  logic [15:0]     ctrl_word,
    input  logic [PW_W-1:0] pw_data,
    output logic            rsp_valid,
    output logic            rsp_abort,
    output logic            erase_req,
    input  logic            media_req,
    output logic            media_grant,
    output logic            sec_enabled,
    output logic            sec_locked,
    output logic            sec_frozen,
    output logic            sec_level_max
);
    logic wr_user, wr_master, clr_user, user_eq, master_eq;

    dsk_pw_bank #(.WORDS(WORDS), .WORD_W(WORD_W), .MASTER_INIT(MASTER_INIT)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_user(wr_user), .wr_master(wr_master), .clr_user(clr_user),
        .pw_in(pw_data), .user_eq(user_eq), .master_eq(master_eq)
    );

    dsk_lock_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .sel_master(ctrl_word[CTRL_SEL_BIT]), .lvl_bit(ctrl_word[CTRL_LVL_BIT]),
        .user_eq(user_eq), .master_eq(master_eq),
        .wr_user(wr_user), .wr_master(wr_master), .clr_user(clr_user),
        .rsp_valid(rsp_valid), .rsp_abort(rsp_abort), .erase_req(erase_req),
        .enabled(sec_enabled), .locked(sec_locked), .frozen(sec_frozen),
        .level_max(sec_level_max)
    );

    // media gate: no access while locked
    assign media_grant = media_req && !sec_locked;
endmodule

// File: rtl/dsk_lock_chk.sv
// Port-level protocol checks for dsk_lock_ctrl, attached by bind.
module dsk_lock_chk
    import dsk_lock_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_cycle,
    input logic       cmd_valid,
    input logic [7:0] cmd_code,
    input logic       rsp_valid,
    input logic       rsp_abort,
    input logic       erase_req,
    input logic       sec_frozen,
    input logic       sec_locked
);
    // R1: a response only follows a command that was not overridden
    a_r1_rsp_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(cmd_valid) && !$past(pwr_cycle)));

    // R5: lock-changing commands while frozen are aborted
    a_r5_frozen_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !pwr_cycle && sec_frozen && cmd_code != CMD_FREEZE &&
         cmd_code >= CMD_SET_PW && cmd_code <= CMD_DIS_PW) |=> rsp_abort);

    // R6: frozen persists until a power cycle
    a_r6_frozen_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_frozen && !pwr_cycle) |=> sec_frozen);

    // R8: erase request only as the answer to an accepted erase unit
    a_r8_erase_cause: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> ($past(cmd_code) == CMD_ERASE_UN && rsp_valid && !rsp_abort));

    // R8: erase request lasts one cycle
    a_r8_erase_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req);

    // R10: the lock is only raised by a power cycle
    a_r10_lock_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_locked) |-> $past(pwr_cycle));
endmodule

bind dsk_lock_ctrl dsk_lock_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .rsp_valid(rsp_valid), .rsp_abort(rsp_abort), .erase_req(erase_req),
    .sec_frozen(sec_frozen), .sec_locked(sec_locked)
);

// File: tb/sim_dsk_lock_ctrl.sv
// Directed bench for dsk_lock_ctrl; one task per scenario.
module sim_dsk_lock_ctrl;
    localparam int unsigned PW_W = 256;

    logic clk = 1'b0;
    logic rst_n, pwr_cycle, cmd_valid, media_req;
    logic [7:0] cmd_code;
    logic [15:0] ctrl_word;
    logic [PW_W-1:0] pw_data;
    logic rsp_valid, rsp_abort, erase_req, media_grant;
    logic sec_enabled, sec_locked, sec_frozen, sec_level_max;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dsk_lock_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .ctrl_word(ctrl_word),
        .pw_data(pw_data), .rsp_valid(rsp_valid), .rsp_abort(rsp_abort),
        .erase_req(erase_req), .media_req(media_req), .media_grant(media_grant),
        .sec_enabled(sec_enabled), .sec_locked(sec_locked),
        .sec_frozen(sec_frozen), .sec_level_max(sec_level_max)
    );

    localparam logic [PW_W-1:0] PW_U  = {8{32'hA5C3_0F01}};
    localparam logic [PW_W-1:0] PW_U2 = {8{32'h1234_5678}};
    localparam logic [PW_W-1:0] PW_M  = {8{32'h5A3C_F0E2}};
    localparam logic [PW_W-1:0] PW_X  = {8{32'hDEAD_0001}};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one command; returns after the response cycle, outputs settled
    task automatic cmd(input logic [7:0] code, input logic [15:0] ctl, input logic [PW_W-1:0] pw);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; ctrl_word = ctl; pw_data = pw;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = 8'h00;
    endtask

    task automatic expect_rsp(input string req, input logic abort_exp);
        check({req, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
        check({req, " rsp_abort"}, {31'd0, rsp_abort}, {31'd0, abort_exp});
    endtask

    task automatic power_cycle();
        @(negedge clk); pwr_cycle = 1'b1;
        @(negedge clk); pwr_cycle = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R12 enabled", {31'd0, sec_enabled}, 32'd0);
        check("R12 locked", {31'd0, sec_locked}, 32'd0);
        check("R12 frozen", {31'd0, sec_frozen}, 32'd0);
        check("R12 level", {31'd0, sec_level_max}, 32'd0);
        check("R12 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R12 erase_req", {31'd0, erase_req}, 32'd0);
        // R12: master initial value all zero, accepted by master unlock after lock
        cmd(8'hF1, 16'h0000, PW_U); power_cycle();
        cmd(8'hF2, 16'h0001, '0);
        expect_rsp("R12 master init unlock", 1'b0);
    endtask

    task automatic t_passthrough();
        do_reset();
        cmd(8'h20, 16'h0001, PW_U);
        expect_rsp("R1 other code", 1'b0);
        check("R1 no state change", {31'd0, sec_enabled}, 32'd0);
        @(negedge clk);
        check("R1 single strobe", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_set_unlock();
        do_reset();
        cmd(8'hF1, 16'h0001, PW_M);
        expect_rsp("R2 set master", 1'b0);
        check("R2 master not enabling", {31'd0, sec_enabled}, 32'd0);
        cmd(8'hF1, 16'h0000, PW_U);
        expect_rsp("R2 set user", 1'b0);
        check("R2 enabled", {31'd0, sec_enabled}, 32'd1);
        check("R2 level high", {31'd0, sec_level_max}, 32'd0);
        power_cycle();
        check("R10 locked after power cycle", {31'd0, sec_locked}, 32'd1);
        media_req = 1'b1; #1;
        check("R11 blocked", {31'd0, media_grant}, 32'd0);
        cmd(8'hF1, 16'h0000, PW_U2);
        expect_rsp("R2 set while locked", 1'b1);
        cmd(8'hF2, 16'h0000, PW_X);
        expect_rsp("R3 wrong user", 1'b1);
        check("R3 still locked", {31'd0, sec_locked}, 32'd1);
        cmd(8'hF2, 16'h0001, PW_M);
        expect_rsp("R3 master unlock", 1'b0);
        check("R3 unlocked", {31'd0, sec_locked}, 32'd0);
        check("R11 granted", {31'd0, media_grant}, 32'd1);
        media_req = 1'b0;
        power_cycle();
        cmd(8'hF2, 16'h0000, PW_U);
        expect_rsp("R3 user unlock", 1'b0);
        check("R3 unlocked by user", {31'd0, sec_locked}, 32'd0);
    endtask

    task automatic t_max_level();
        do_reset();
        cmd(8'hF1, 16'h0001, PW_M);
        cmd(8'hF1, 16'h0100, PW_U);
        check("R2 level max", {31'd0, sec_level_max}, 32'd1);
        power_cycle();
        cmd(8'hF2, 16'h0001, PW_M);
        expect_rsp("R4 master unlock at max", 1'b1);
        check("R4 still locked", {31'd0, sec_locked}, 32'd1);
        cmd(8'hF2, 16'h0000, PW_U);
        expect_rsp("R4 user unlock at max", 1'b0);
        cmd(8'hF3, 16'h0000, '0);
        expect_rsp("R8 prepare", 1'b0);
        cmd(8'hF4, 16'h0000, PW_U);
        expect_rsp("R4 user erase at max", 1'b1);
        check("R4 no erase", {31'd0, erase_req}, 32'd0);
        cmd(8'hF3, 16'h0000, '0);
        cmd(8'hF4, 16'h0001, PW_M);
        expect_rsp("R4 master erase at max", 1'b0);
        check("R8 erase pulse", {31'd0, erase_req}, 32'd1);
        check("R8 disabled", {31'd0, sec_enabled}, 32'd0);
        @(negedge clk);
        check("R8 pulse one cycle", {31'd0, erase_req}, 32'd0);
    endtask

    task automatic t_erase_user();
        do_reset();
        cmd(8'hF1, 16'h0000, PW_U);
        power_cycle();
        cmd(8'hF3, 16'h0000, '0);
        cmd(8'hF4, 16'h0000, PW_U);
        expect_rsp("R8 erase with user", 1'b0);
        check("R8 erase_req", {31'd0, erase_req}, 32'd1);
        check("R8 lock cleared", {31'd0, sec_locked}, 32'd0);
        cmd(8'hF4, 16'h0000, PW_U);
        expect_rsp("R8 erase without prepare", 1'b1);
    endtask

    task automatic t_prepare_break();
        do_reset();
        cmd(8'hF1, 16'h0000, PW_U);
        cmd(8'hF3, 16'h0000, '0);
        cmd(8'h00, 16'h0000, '0);
        cmd(8'hF4, 16'h0000, PW_U);
        expect_rsp("R9 prepare cancelled", 1'b1);
        check("R9 no erase", {31'd0, erase_req}, 32'd0);
        check("R9 still enabled", {31'd0, sec_enabled}, 32'd1);
        cmd(8'hF3, 16'h0000, '0);
        cmd(8'hF4, 16'h0000, PW_X);
        expect_rsp("R9 wrong pw erase", 1'b1);
        cmd(8'hF4, 16'h0000, PW_U);
        expect_rsp("R9 prepare consumed", 1'b1);
    endtask

    task automatic t_freeze();
        do_reset();
        cmd(8'hF1, 16'h0000, PW_U);
        cmd(8'hF5, 16'h0000, '0);
        expect_rsp("R5 freeze", 1'b0);
        check("R5 frozen", {31'd0, sec_frozen}, 32'd1);
        cmd(8'hF1, 16'h0000, PW_U2);
        expect_rsp("R5 set pw frozen", 1'b1);
        cmd(8'hF2, 16'h0000, PW_U);
        expect_rsp("R5 unlock frozen", 1'b1);
        cmd(8'hF3, 16'h0000, '0);
        expect_rsp("R5 prepare frozen", 1'b1);
        cmd(8'hF4, 16'h0000, PW_U);
        expect_rsp("R5 erase frozen", 1'b1);
        check("R5 no erase", {31'd0, erase_req}, 32'd0);
        cmd(8'hF6, 16'h0000, PW_U);
        expect_rsp("R5 disable frozen", 1'b1);
        check("R5 still enabled", {31'd0, sec_enabled}, 32'd1);
        cmd(8'hF5, 16'h0000, '0);
        expect_rsp("R5 refreeze", 1'b0);
        check("R6 frozen kept", {31'd0, sec_frozen}, 32'd1);
        power_cycle();
        check("R6 frozen cleared", {31'd0, sec_frozen}, 32'd0);
        check("R10 locked", {31'd0, sec_locked}, 32'd1);
        cmd(8'hF2, 16'h0000, PW_U);
        expect_rsp("R2 old user pw kept", 1'b0);
    endtask

    task automatic t_disable();
        do_reset();
        cmd(8'hF1, 16'h0001, PW_M);
        cmd(8'hF1, 16'h0000, PW_U);
        cmd(8'hF6, 16'h0000, PW_X);
        expect_rsp("R7 wrong disable", 1'b1);
        cmd(8'hF6, 16'h0000, PW_U);
        expect_rsp("R7 disable", 1'b0);
        check("R7 disabled", {31'd0, sec_enabled}, 32'd0);
        cmd(8'hF6, 16'h0000, PW_U);
        expect_rsp("R7 disable when off", 1'b1);
        cmd(8'hF1, 16'h0000, PW_U2);
        power_cycle();
        cmd(8'hF2, 16'h0001, PW_M);
        expect_rsp("R7 master kept", 1'b0);
        power_cycle();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 8'hF2; ctrl_word = 16'h0000; pw_data = PW_U2;
        pwr_cycle = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; pwr_cycle = 1'b0;
        check("R10 command dropped", {31'd0, rsp_valid}, 32'd0);
        check("R10 lock kept", {31'd0, sec_locked}, 32'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; pwr_cycle = 1'b0; cmd_valid = 1'b0; media_req = 1'b0;
        cmd_code = 8'h00; ctrl_word = 16'h0000; pw_data = '0;
        t_reset_state();
        t_passthrough();
        t_set_unlock();
        t_max_level();
        t_erase_user();
        t_prepare_break();
        t_freeze();
        t_disable();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule